// File: doc/BRIEF.md
# Parallel Micro-op Register-Group Expander

This block sits between an in-order micro-op queue and the issue stage of a vector pipeline. Each cycle it can take up to two micro-ops from the head of the queue. It splits every micro-op into one expanded micro-op per register of its register group: a micro-op whose group spans N registers becomes N expanded micro-ops numbered 0 to N-1. The expanded micro-ops leave through two parallel output slots, and the block keeps them in strict program order.

The expanded micro-ops are packed. When a micro-op has only one expanded micro-op left, its neighbour in program order fills the second output slot in that same cycle. A two-entry in-order buffer holds the micro-ops that are being expanded. Each entry has its own progress counter. The block drives one ready per input slot back to the queue and obeys a single downstream ready. A synchronous flush drops everything it holds.

Top module: `vexp_expander`

## Requirements
- R1: The 3-bit group code selects the number of expanded micro-ops: code 0 gives 1, code 1 gives 2, code 2 gives 4 and code 3 gives 8. Codes 4 to 7 (fractional or reserved groups) give exactly 1.
- R2: The expanded micro-ops of one micro-op carry indices 0, 1, ... N-1 in ascending order, and each carries the micro-op's payload unchanged. When both output slots come from the same micro-op, slot 0 holds the lower index.
- R3: Input slot 0 is older than input slot 1. Expanded micro-ops leave in program order, slot 0 before slot 1 and earlier cycles before later ones. Output slot 1 is never valid unless output slot 0 is valid.
- R4: Whenever at least two expanded micro-ops are buffered, both output slots are valid. If the oldest micro-op has one expanded micro-op left, index 0 of the next micro-op fills slot 1 in the same cycle. With the queue always supplying and downstream always ready, a run of T expanded micro-ops takes ceil(T/2) valid output cycles.
- R5: in_rdy[0] is high when at least one buffer entry will be free after the completions of the current cycle. in_rdy[1] is high when both entries will be free, so in_rdy[1] implies in_rdy[0]. Input slot 1 is taken only in a cycle where input slot 0 is also taken.
- R6: While out_rdy is low, every valid output slot keeps its valid flag, payload and index into the next cycle.
- R7: While flush is high, both in_rdy bits and both out_vld bits are low. In the cycle after flush, no output is valid and nothing buffered before the flush ever reappears.
- R8: After reset, both output slots are invalid and both in_rdy bits are high.
- R9: An accepted micro-op produces no output in the cycle in which it is accepted. Its first expanded micro-op can appear in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous discard of all buffered micro-ops |
| in_vld | input | 2 | Per input slot: micro-op present (slot 0 oldest) |
| in_pay | input | 2 x PAY_W | Per input slot: opaque micro-op payload |
| in_lmul | input | 2 x 3 | Per input slot: register-group code (see R1) |
| in_rdy | output | 2 | Per input slot: micro-op taken this cycle if valid |
| out_vld | output | 2 | Per output slot: expanded micro-op present |
| out_pay | output | 2 x PAY_W | Per output slot: payload of the source micro-op |
| out_idx | output | 2 x 3 | Per output slot: expansion index within the group |
| out_rdy | input | 1 | Downstream accepts both output slots this cycle |

## Verification
The hardest case to produce from the ports is a slot hand-off under back-pressure. The oldest micro-op is down to its last register, a younger micro-op of some other group size waits behind it, and downstream ready drops in the same cycle that a freed entry is being refilled. Every ordered pair of the eight group codes runs with downstream always ready, and each pair's cycle count is checked against ceil(T/2). Long sequences of random group codes then run under alternating and pseudo-random downstream ready, which reaches the hand-off with stalls on either side. Every output cycle is compared against an expected stream built in the bench, and held slots are checked for stability.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

  localparam int NSLOT  = 2;
  localparam int LMUL_W = 3;
  localparam int MAX_LG = 3;
  localparam int IDX_W  = MAX_LG;
  localparam int LEN_W  = MAX_LG + 1;

  typedef logic [LMUL_W-1:0] lmul_t;
  typedef logic [LEN_W-1:0]  len_t;
  typedef logic [IDX_W-1:0]  idx_t;

  // number of registers in a group; codes with the top bit set collapse to one
  function automatic len_t grp_len(lmul_t code);
    len_t n;
    if (code[LMUL_W-1]) begin
      n = len_t'(1);
    end else begin
      n = len_t'(1) << code[LMUL_W-2:0];
    end
    return n;
  endfunction

  // expanded micro-ops still owed by an entry
  function automatic len_t rem_of(len_t len, idx_t cnt);
    return len - len_t'(cnt);
  endfunction

  // how many of them one cycle can drain from a single entry
  function automatic logic [1:0] step_of(len_t rem);
    logic [1:0] s;
    if (rem >= len_t'(2)) begin
      s = 2'd2;
    end else begin
      s = rem[1:0];
    end
    return s;
  endfunction

endpackage

// File: rtl/vexp_admit.sv
module vexp_admit
  import vexp_pkg::*;
(
  input  logic             flush,
  input  logic [1:0]       occ,
  input  logic [1:0]       n_done,
  input  logic [NSLOT-1:0] in_vld,
  output logic [NSLOT-1:0] in_rdy,
  output logic [1:0]       push_cnt
);

  localparam logic [2:0] DEPTH = 3'(NSLOT);

  logic [2:0] free_after;
  logic       take0;
  logic       take1;

  always_comb begin
    free_after = DEPTH - {1'b0, occ} + {1'b0, n_done};
    in_rdy[0]  = !flush && (free_after >= 3'd1);
    in_rdy[1]  = !flush && (free_after >= 3'd2);
  end

  assign take0    = in_vld[0] && in_rdy[0];
  assign take1    = take0 && in_vld[1] && in_rdy[1];
  assign push_cnt = {1'b0, take0} + {1'b0, take1};

endmodule

// File: rtl/vexp_slot_buf.sv
module vexp_slot_buf
  import vexp_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [1:0]                   take_old,
  input  logic                         take_yng,
  input  logic                         done_old,
  input  logic                         done_yng,
  input  logic [1:0]                   n_done,
  input  logic [1:0]                   push_cnt,
  input  logic [NSLOT-1:0][PAY_W-1:0]  push_pay,
  input  len_t [NSLOT-1:0]             push_len,
  output logic                         old_vld,
  output logic [PAY_W-1:0]             old_pay,
  output len_t                         old_len,
  output idx_t                         old_cnt,
  output logic                         yng_vld,
  output logic [PAY_W-1:0]             yng_pay,
  output len_t                         yng_len,
  output idx_t                         yng_cnt,
  output logic [1:0]                   occ
);

  logic                        hd_q;
  logic [1:0]                  occ_q;
  logic                        hd_n;
  logic [1:0]                  keep;
  logic                        tail0;
  logic                        tail1;

  logic [NSLOT-1:0]            ent_vld;
  logic [NSLOT-1:0][PAY_W-1:0] ent_pay;
  len_t [NSLOT-1:0]            ent_len;
  idx_t [NSLOT-1:0]            ent_cnt;

  // pointer bookkeeping: completed entries leave from the head, new ones land behind survivors
  assign hd_n  = hd_q ^ n_done[0];
  assign keep  = occ_q - n_done;
  assign tail0 = hd_n ^ keep[0];
  assign tail1 = ~tail0;

  for (genvar p = 0; p < NSLOT; p++) begin : g_ent
    logic             is_old;
    logic [1:0]       take_p;
    logic             done_p;
    logic             push0_here;
    logic             push1_here;
    logic             vld_r;
    logic [PAY_W-1:0] pay_r;
    len_t             len_r;
    idx_t             cnt_r;

    assign is_old     = (hd_q == 1'(p));
    assign take_p     = is_old ? take_old : {1'b0, take_yng};
    assign done_p     = is_old ? done_old : done_yng;
    assign push0_here = (push_cnt != 2'd0) && (tail0 == 1'(p));
    assign push1_here = (push_cnt == 2'd2) && (tail1 == 1'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        pay_r <= '0;
        len_r <= '0;
        cnt_r <= '0;
      end else if (flush) begin
        vld_r <= 1'b0;
        cnt_r <= '0;
      end else if (push0_here || push1_here) begin
        vld_r <= 1'b1;
        pay_r <= push1_here ? push_pay[1] : push_pay[0];
        len_r <= push1_here ? push_len[1] : push_len[0];
        cnt_r <= '0;
      end else if (done_p) begin
        vld_r <= 1'b0;
        cnt_r <= '0;
      end else begin
        cnt_r <= cnt_r + idx_t'(take_p);
      end
    end

    assign ent_vld[p] = vld_r;
    assign ent_pay[p] = pay_r;
    assign ent_len[p] = len_r;
    assign ent_cnt[p] = cnt_r;

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      vld_r |-> (len_t'(cnt_r) < len_r)) else $error("entry counter past group end"); // R2

    AST_PUSH_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (push0_here || push1_here) && !flush |-> (!vld_r || done_p)) else $error("push over live entry"); // R5
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q  <= 1'b0;
      occ_q <= 2'd0;
    end else if (flush) begin
      hd_q  <= 1'b0;
      occ_q <= 2'd0;
    end else begin
      hd_q  <= hd_n;
      occ_q <= keep + push_cnt;
    end
  end

  assign old_vld = ent_vld[hd_q];
  assign old_pay = ent_pay[hd_q];
  assign old_len = ent_len[hd_q];
  assign old_cnt = ent_cnt[hd_q];
  assign yng_vld = ent_vld[~hd_q];
  assign yng_pay = ent_pay[~hd_q];
  assign yng_len = ent_len[~hd_q];
  assign yng_cnt = ent_cnt[~hd_q];
  assign occ     = occ_q;

  AST_OCC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_vld) == int'(occ_q)) else $error("occupancy out of step with entries"); // R5

  AST_YOUNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    yng_vld |-> old_vld) else $error("younger entry without older one"); // R3

endmodule

// File: rtl/vexp_packer.sv
module vexp_packer
  import vexp_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush,
  input  logic                        out_rdy,
  input  logic                        old_vld,
  input  logic [PAY_W-1:0]            old_pay,
  input  len_t                        old_len,
  input  idx_t                        old_cnt,
  input  logic                        yng_vld,
  input  logic [PAY_W-1:0]            yng_pay,
  input  len_t                        yng_len,
  input  idx_t                        yng_cnt,
  output logic [NSLOT-1:0]            out_vld,
  output logic [NSLOT-1:0][PAY_W-1:0] out_pay,
  output logic [NSLOT-1:0][IDX_W-1:0] out_idx,
  output logic [1:0]                  take_old,
  output logic                        take_yng,
  output logic                        done_old,
  output logic                        done_yng,
  output logic [1:0]                  n_done
);

  len_t       rem_old;
  logic [1:0] step_old;
  logic       old_two;
  logic       fire;

  assign rem_old  = rem_of(old_len, old_cnt);
  assign step_old = step_of(rem_old);
  assign old_two  = old_vld && (step_old == 2'd2);
  assign fire     = out_rdy && !flush;

  // slot 0 always shows the oldest entry; slot 1 shows its next index or the neighbour's first
  always_comb begin
    out_vld[0] = old_vld && !flush;
    out_pay[0] = old_pay;
    out_idx[0] = old_cnt;
    if (old_two) begin
      out_vld[1] = !flush;
      out_pay[1] = old_pay;
      out_idx[1] = old_cnt + idx_t'(1);
    end else begin
      out_vld[1] = yng_vld && !flush;
      out_pay[1] = yng_pay;
      out_idx[1] = yng_cnt;
    end
  end

  always_comb begin
    take_old = (fire && old_vld) ? step_old : 2'd0;
    take_yng = fire && !old_two && yng_vld;
    done_old = fire && old_vld && (rem_old <= len_t'(2));
    done_yng = take_yng && (yng_len == (len_t'(yng_cnt) + len_t'(1)));
    n_done   = {1'b0, done_old} + {1'b0, done_yng};
  end

  AST_SLOT1_NEEDS_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld[1] |-> out_vld[0]) else $error("slot 1 valid without slot 0"); // R3

  AST_YOUNG_AFTER_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    take_yng |-> done_old) else $error("younger drained before older finished"); // R4

  AST_REM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    old_vld |-> (rem_old != '0)) else $error("live entry with nothing left"); // R1

endmodule

// File: rtl/vexp_expander.sv
module vexp_expander
  import vexp_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic [NSLOT-1:0]             in_vld,
  input  logic [NSLOT-1:0][PAY_W-1:0]  in_pay,
  input  logic [NSLOT-1:0][LMUL_W-1:0] in_lmul,
  output logic [NSLOT-1:0]             in_rdy,
  output logic [NSLOT-1:0]             out_vld,
  output logic [NSLOT-1:0][PAY_W-1:0]  out_pay,
  output logic [NSLOT-1:0][IDX_W-1:0]  out_idx,
  input  logic                         out_rdy
);

  logic             old_vld;
  logic [PAY_W-1:0] old_pay;
  len_t             old_len;
  idx_t             old_cnt;
  logic             yng_vld;
  logic [PAY_W-1:0] yng_pay;
  len_t             yng_len;
  idx_t             yng_cnt;
  logic [1:0]       occ;
  logic [1:0]       take_old;
  logic             take_yng;
  logic             done_old;
  logic             done_yng;
  logic [1:0]       n_done;
  logic [1:0]       push_cnt;
  len_t [NSLOT-1:0] push_len;

  for (genvar k = 0; k < NSLOT; k++) begin : g_dec
    assign push_len[k] = grp_len(in_lmul[k]);
  end

  vexp_admit u_admit (
    .flush    (flush),
    .occ      (occ),
    .n_done   (n_done),
    .in_vld   (in_vld),
    .in_rdy   (in_rdy),
    .push_cnt (push_cnt)
  );

  vexp_slot_buf #(.PAY_W(PAY_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .take_old (take_old),
    .take_yng (take_yng),
    .done_old (done_old),
    .done_yng (done_yng),
    .n_done   (n_done),
    .push_cnt (push_cnt),
    .push_pay (in_pay),
    .push_len (push_len),
    .old_vld  (old_vld),
    .old_pay  (old_pay),
    .old_len  (old_len),
    .old_cnt  (old_cnt),
    .yng_vld  (yng_vld),
    .yng_pay  (yng_pay),
    .yng_len  (yng_len),
    .yng_cnt  (yng_cnt),
    .occ      (occ)
  );

  vexp_packer #(.PAY_W(PAY_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .out_rdy  (out_rdy),
    .old_vld  (old_vld),
    .old_pay  (old_pay),
    .old_len  (old_len),
    .old_cnt  (old_cnt),
    .yng_vld  (yng_vld),
    .yng_pay  (yng_pay),
    .yng_len  (yng_len),
    .yng_cnt  (yng_cnt),
    .out_vld  (out_vld),
    .out_pay  (out_pay),
    .out_idx  (out_idx),
    .take_old (take_old),
    .take_yng (take_yng),
    .done_old (done_old),
    .done_yng (done_yng),
    .n_done   (n_done)
  );

  AST_RDY_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy[1] |-> in_rdy[0]) else $error("second ready without first"); // R5

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (out_vld == '0)) else $error("output valid after flush"); // R7

  AST_STALL_HOLD0: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (!out_rdy && out_vld[0]) |=> (out_vld[0] && $stable(out_pay[0]) && $stable(out_idx[0])))
    else $error("slot 0 moved under stall"); // R6

  AST_STALL_HOLD1: assert property (@(posedge clk) disable iff (!rst_n || flush)
    (!out_rdy && out_vld[1]) |=> (out_vld[1] && $stable(out_pay[1]) && $stable(out_idx[1])))
    else $error("slot 1 moved under stall"); // R6

endmodule

// File: tb/vexp_expander_tb.sv
module vexp_expander_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PAY_W      = 16;
  localparam int MAXOPS     = 512;
  localparam int MAXTOK     = 4096;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  flush;
  logic [1:0]            in_vld;
  logic [1:0][PAY_W-1:0] in_pay;
  logic [1:0][2:0]       in_lmul;
  logic [1:0]            in_rdy;
  logic [1:0]            out_vld;
  logic [1:0][PAY_W-1:0] out_pay;
  logic [1:0][2:0]       out_idx;
  logic                  out_rdy;

  int n_chk = 0;
  int n_bad = 0;

  logic [PAY_W-1:0] op_pay  [MAXOPS];
  logic [2:0]       op_lmul [MAXOPS];
  int               n_ops;
  logic [PAY_W-1:0] exp_pay [MAXTOK];
  int               exp_idx [MAXTOK];
  int               n_tok;
  logic [15:0]      lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  vexp_expander #(.PAY_W(PAY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_vld(in_vld), .in_pay(in_pay), .in_lmul(in_lmul), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_pay(out_pay), .out_idx(out_idx), .out_rdy(out_rdy)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", 150000);
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // group size from the code, written as a lookup
  function automatic int blen(input logic [2:0] c);
    case (c)
      3'd0: return 1;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic lf_step();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic build_tokens();
    n_tok = 0;
    for (int i = 0; i < n_ops; i++) begin
      for (int j = 0; j < blen(op_lmul[i]); j++) begin
        exp_pay[n_tok] = op_pay[i];
        exp_idx[n_tok] = j;
        n_tok++;
      end
    end
  endtask

  // mode 0: always ready, 1: alternating ready, 2: pseudo-random ready
  task automatic run_seq(input int mode, input string name);
    int qh = 0;
    int ep = 0;
    int vcyc = 0;
    int cyc = 0;
    bit prev_stall0 = 0;
    bit prev_stall1 = 0;
    logic [PAY_W-1:0] pp0 = '0, pp1 = '0;
    logic [2:0] pi0 = '0, pi1 = '0;
    build_tokens();
    while (!(qh == n_ops && ep == n_tok) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      in_vld[0]  = (qh < n_ops);
      in_pay[0]  = op_pay[qh];
      in_lmul[0] = op_lmul[qh];
      in_vld[1]  = (qh + 1 < n_ops);
      in_pay[1]  = op_pay[qh+1];
      in_lmul[1] = op_lmul[qh+1];
      lf_step();
      case (mode)
        0: out_rdy = 1'b1;
        1: out_rdy = cyc[0];
        default: out_rdy = lf[3] | lf[7];
      endcase
      #1;
      if (prev_stall0)
        chk(out_vld[0] && out_pay[0] == pp0 && out_idx[0] == pi0, "R6 slot0 hold", longint'(out_pay[0]), longint'(pp0));
      if (prev_stall1)
        chk(out_vld[1] && out_pay[1] == pp1 && out_idx[1] == pi1, "R6 slot1 hold", longint'(out_pay[1]), longint'(pp1));
      prev_stall0 = !out_rdy && out_vld[0];
      prev_stall1 = !out_rdy && out_vld[1];
      pp0 = out_pay[0]; pi0 = out_idx[0];
      pp1 = out_pay[1]; pi1 = out_idx[1];
      if (out_vld[1] && !out_vld[0])
        chk(1'b0, "R3 slot1 without slot0", 1, 0);
      if (in_rdy[1] && !in_rdy[0])
        chk(1'b0, "R5 ready nesting", 2, 3);
      if (out_vld[0]) vcyc++;
      if (out_rdy) begin
        for (int k = 0; k < 2; k++) begin
          if (out_vld[k]) begin
            if (ep >= n_tok) begin
              chk(1'b0, "R1 extra output", ep, n_tok);
            end else begin
              chk(out_pay[k] == exp_pay[ep], "R3 payload order", longint'(out_pay[k]), longint'(exp_pay[ep]));
              chk(int'(out_idx[k]) == exp_idx[ep], "R2 index", longint'(out_idx[k]), exp_idx[ep]);
            end
            ep++;
          end
        end
      end
      if (in_vld[0] && in_rdy[0]) begin
        qh++;
        if (in_vld[1] && in_rdy[1]) qh++;
      end
    end
    @(negedge clk);
    in_vld = '0;
    out_rdy = 1'b1;
    #1;
    chk(ep == n_tok, {"R1 token count ", name}, ep, n_tok);
    chk(out_vld == 2'b00, {"R1 idle after run ", name}, out_vld, 0);
    if (mode == 0)
      chk(vcyc == (n_tok + 1) / 2, {"R4 packed cycles ", name}, vcyc, (n_tok + 1) / 2);
  endtask

  task automatic expect_out(input bit v0, input int p0, input int i0,
                            input bit v1, input int p1, input int i1, input string tag);
    chk(out_vld[0] == v0, {tag, " vld0"}, out_vld[0], v0);
    if (v0) begin
      chk(int'(out_pay[0]) == p0, {tag, " pay0"}, out_pay[0], p0);
      chk(int'(out_idx[0]) == i0, {tag, " idx0"}, out_idx[0], i0);
    end
    chk(out_vld[1] == v1, {tag, " vld1"}, out_vld[1], v1);
    if (v1) begin
      chk(int'(out_pay[1]) == p1, {tag, " pay1"}, out_pay[1], p1);
      chk(int'(out_idx[1]) == i1, {tag, " idx1"}, out_idx[1], i1);
    end
  endtask

  task automatic step();
    @(negedge clk);
    in_vld = '0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; in_vld = '0; in_pay = '0; in_lmul = '0; out_rdy = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_vld == 2'b00, "R8 reset outputs", out_vld, 0);
    chk(in_rdy == 2'b11, "R8 reset ready", in_rdy, 3);

    // two groups of four, loaded together
    @(negedge clk);
    out_rdy = 1'b1;
    in_vld = 2'b11; in_pay[0] = 16'h00A0; in_lmul[0] = 3'd2; in_pay[1] = 16'h00B0; in_lmul[1] = 3'd2;
    #1;
    chk(in_rdy == 2'b11, "R5 both taken when empty", in_rdy, 3);
    chk(out_vld == 2'b00, "R9 no output on accept cycle", out_vld, 0);
    step();
    expect_out(1, 'hA0, 0, 1, 'hA0, 1, "R2 c1");
    chk(in_rdy == 2'b00, "R5 full and nothing completing", in_rdy, 0);
    step();
    expect_out(1, 'hA0, 2, 1, 'hA0, 3, "R2 c2");
    chk(in_rdy == 2'b01, "R5 one entry completing", in_rdy, 1);
    step();
    expect_out(1, 'hB0, 0, 1, 'hB0, 1, "R3 c3");
    step();
    expect_out(1, 'hB0, 2, 1, 'hB0, 3, "R3 c4");
    step();
    expect_out(0, 0, 0, 0, 0, 0, "R4 drained");

    // single group followed by a group of two: hand-off into slot 1
    @(negedge clk);
    in_vld = 2'b11; in_pay[0] = 16'h0011; in_lmul[0] = 3'd0; in_pay[1] = 16'h0022; in_lmul[1] = 3'd1;
    #1;
    step();
    expect_out(1, 'h11, 0, 1, 'h22, 0, "R4 hand-off");
    step();
    expect_out(1, 'h22, 1, 0, 0, 0, "R4 tail");
    step();
    expect_out(0, 0, 0, 0, 0, 0, "R4 idle");

    // flush in the middle of two groups of eight
    @(negedge clk);
    in_vld = 2'b11; in_pay[0] = 16'h0701; in_lmul[0] = 3'd3; in_pay[1] = 16'h0702; in_lmul[1] = 3'd3;
    #1;
    step();
    step();
    expect_out(1, 'h701, 2, 1, 'h701, 3, "R1 group of eight");
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(in_rdy == 2'b00, "R7 ready low in flush", in_rdy, 0);
    chk(out_vld == 2'b00, "R7 outputs low in flush", out_vld, 0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    chk(out_vld == 2'b00, "R7 empty after flush", out_vld, 0);
    chk(in_rdy == 2'b11, "R7 ready after flush", in_rdy, 3);

    // every ordered pair of group codes, always ready
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        n_ops = 2;
        op_pay[0] = 16'(16'h1000 + a * 16 + b); op_lmul[0] = 3'(a);
        op_pay[1] = 16'(16'h2000 + a * 16 + b); op_lmul[1] = 3'(b);
        run_seq(0, "pair");
      end
    end

    // long random mixes under three ready patterns
    for (int m = 0; m < 3; m++) begin
      n_ops = 200;
      for (int i = 0; i < n_ops; i++) begin
        lf_step();
        op_pay[i]  = 16'(i * 97 + 3 + m * 4000);
        op_lmul[i] = lf[2:0];
      end
      run_seq(m, "random mix");
    end

    summary();
    $finish;
  end

endmodule